// File: doc/BRIEF.md
# Floating-Point Exception Status and Deferred Trap Unit

This block keeps the sticky exception record of a floating-point datapath and decides when a trap goes to the host. Each accepted arithmetic operation reports its exception conditions as strobes, and the block ORs them into a status word. A control mask, one bit per condition, decides which conditions are handled internally and which must reach the host. A masked condition only sets its flag. An unmasked flag sets a summary bit.

The trap is not raised when the faulting operation completes. Integer code keeps running. The trap is requested when the next floating-point operation, wait or waiting clear is presented. That instruction is refused whether or not it would itself be valid, and it stays refused until the flags are cleared through a non-waiting clear or an initialize. Loading the control word never waits. Unmasking a condition whose flag is already set therefore creates a pending trap.

Top module: `fpx_trap_unit`

## Requirements
- R1: During and after reset the flags and the summary bit are zero, every mask bit is one, and `trap_req` is low.
- R2: An accepted floating-point operation (class 0) ORs `exc_in` into the flags at the next clock edge. A set flag stays set through later operations that do not report that condition. Flag positions: invalid 0, denormal 1, zero-divide 2, overflow 3, underflow 4, precision 5, stack fault 6.
- R3: A stack fault (`exc_in` bit 6) also sets the invalid-operation flag (bit 0), and the invalid mask governs it.
- R4: A condition whose mask bit is one sets its flag but leaves the summary bit and `trap_req` low.
- R5: `status_word` bit 7 is the OR over bits 5..0 of (flag AND NOT mask), computed from the current flags and masks. A mask load that exposes a set flag raises it right after the load edge.
- R6: While the summary bit is one, a floating-point operation (class 0), wait (class 1) or waiting clear (class 2) drives `trap_req` high in the cycle it is presented. The instruction is not executed, so the flags do not change and its `exc_in` is ignored.
- R7: While the summary bit is zero, a wait or a floating-point operation leaves `trap_req` low.
- R8: A non-waiting clear (class 3) clears flags 6..0 and the summary bit at the next edge, even with a trap pending, and never raises `trap_req`.
- R9: A waiting clear (class 2) with no trap pending clears flags 6..0 at the next edge.
- R10: Initialize (class 4) clears all flags and sets every mask bit at the next edge, even with a trap pending, and never raises `trap_req`.
- R11: A control-word load (class 5) copies `cw_wdata` into the masks at the next edge, even with a trap pending, and never raises `trap_req`.
- R12: `stall` is high exactly when the summary bit is one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | An instruction class is presented this cycle |
| instr_class | input | 3 | 0 op, 1 wait, 2 waiting clear, 3 non-waiting clear, 4 initialize, 5 control load |
| exc_in | input | 7 | Exception strobes of the presented operation |
| cw_wdata | input | 6 | Mask bits for a control-word load |
| status_word | output | 8 | Summary bit 7, sticky flags 6..0 |
| ctrl_mask | output | 6 | Current mask bits |
| trap_req | output | 1 | Presented instruction is refused and a trap is requested |
| stall | output | 1 | Floating-point instructions are held back |

## Verification
The assertions assume that the decoder presents at most one instruction class per cycle and that the class code is one of the six defined values. They also assume that `exc_in` carries meaning only alongside a class-0 operation. The bench drives `instr_class`, `exc_in` and `cw_wdata` from one task, away from the clock edge, and zeroes `exc_in` between instructions. It uses only the six legal codes, and it also presents instructions while a trap is pending to exercise the refusal path.

// File: rtl/fpx_pkg.sv
// Shared constants and types for the floating-point exception unit.
// Assumes one instruction class per cycle; stack fault sits above the maskable set.
package fpx_pkg;
    localparam int FPX_NUM_MASKED  = 6;
    localparam int FPX_NUM_FLAGS   = FPX_NUM_MASKED + 1;
    localparam int FPX_IDX_INVALID = 0;
    localparam int FPX_IDX_STACK   = FPX_NUM_MASKED;

    typedef enum logic [2:0] {
        CLS_FPOP       = 3'd0,
        CLS_WAIT       = 3'd1,
        CLS_CLR_WAIT   = 3'd2,
        CLS_CLR_NOWAIT = 3'd3,
        CLS_INIT       = 3'd4,
        CLS_LDCW       = 3'd5
    } fpx_cls_e;

    typedef struct packed {
        logic trap;
        logic exec_op;
        logic clear;
        logic init;
        logic load_cw;
    } fpx_cmd_t;
endpackage

// File: rtl/fpx_issue_decode.sv
// Turns the presented instruction class and the pending state into one command.
// Waiting classes trap while a trap is pending; non-waiting classes always run.
module fpx_issue_decode
    import fpx_pkg::*;
(
    input  logic           instr_valid,
    input  logic [2:0]     instr_class,
    input  logic           pending,
    output fpx_cmd_t       cmd
);
    // Command selection for the current cycle.
    always_comb begin
        cmd = '0;
        if (instr_valid) begin
            case (instr_class)
                CLS_FPOP: begin
                    cmd.trap    = pending;
                    cmd.exec_op = !pending;
                end
                CLS_WAIT:       cmd.trap = pending;
                CLS_CLR_WAIT: begin
                    cmd.trap  = pending;
                    cmd.clear = !pending;
                end
                CLS_CLR_NOWAIT: cmd.clear   = 1'b1;
                CLS_INIT:       cmd.init    = 1'b1;
                CLS_LDCW:       cmd.load_cw = 1'b1;
                default:        cmd = '0;
            endcase
        end
    end
endmodule

// File: rtl/fpx_sticky_flags.sv
// Sticky exception flag register; a stack fault also records invalid operation.
// Assumes clear and set are never requested together by the decoder.
module fpx_sticky_flags #(
    parameter int NUM_MASKED = 6,
    localparam int NF = NUM_MASKED + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [NF-1:0] raw_exc,
    input  logic          clear,
    output logic [NF-1:0] flags
);
    logic [NF-1:0] set_vec;

    // Fold the stack-fault strobe into the invalid-operation position.
    always_comb begin
        set_vec    = raw_exc;
        set_vec[0] = raw_exc[0] | raw_exc[NF-1];
    end

    // Hold, accumulate or clear the flags.
    always_ff @(posedge clk) begin
        if (!rst_n)      flags <= '0;
        else if (clear)  flags <= '0;
        else if (set_en) flags <= flags | set_vec;
    end
endmodule

// File: rtl/fpx_ctrl_mask.sv
// Exception mask register: preset to all ones by reset or initialize.
// Assumes load and init are mutually exclusive.
module fpx_ctrl_mask #(
    parameter int NUM_MASKED = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  init,
    input  logic                  load,
    input  logic [NUM_MASKED-1:0] wdata,
    output logic [NUM_MASKED-1:0] mask
);
    // Update the masks on reset, initialize or control-word load.
    always_ff @(posedge clk) begin
        if (!rst_n || init) mask <= '1;
        else if (load)      mask <= wdata;
    end
endmodule

// File: rtl/fpx_summary.sv
// Summary bit: any maskable flag set while its mask bit is clear.
// Purely combinational, so it follows every flag or mask change.
module fpx_summary #(
    parameter int NUM_MASKED = 6
) (
    input  logic [NUM_MASKED-1:0] flags,
    input  logic [NUM_MASKED-1:0] mask,
    output logic                  summary
);
    logic [NUM_MASKED-1:0] exposed;

    for (genvar i = 0; i < NUM_MASKED; i++) begin : g_expose
        assign exposed[i] = flags[i] & ~mask[i];
    end

    // Reduce the exposed vector.
    always_comb summary = |exposed;
endmodule

// File: rtl/fpx_trap_unit.sv
// Top of the exception status and deferred trap unit.
// Assumes the instruction decoder presents one class per cycle and drives exc_in only with ops.
module fpx_trap_unit #(
    parameter int NUM_MASKED = fpx_pkg::FPX_NUM_MASKED,
    localparam int NF = NUM_MASKED + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  instr_valid,
    input  logic [2:0]            instr_class,
    input  logic [NF-1:0]         exc_in,
    input  logic [NUM_MASKED-1:0] cw_wdata,
    output logic [NF:0]           status_word,
    output logic [NUM_MASKED-1:0] ctrl_mask,
    output logic                  trap_req,
    output logic                  stall
);
    import fpx_pkg::*;

    fpx_cmd_t      cmd;
    logic [NF-1:0] flags;
    logic          summary;

    fpx_issue_decode i_decode (
        .instr_valid (instr_valid),
        .instr_class (instr_class),
        .pending     (summary),
        .cmd         (cmd)
    );

    fpx_sticky_flags #(.NUM_MASKED(NUM_MASKED)) i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (cmd.exec_op),
        .raw_exc (exc_in),
        .clear   (cmd.clear | cmd.init),
        .flags   (flags)
    );

    fpx_ctrl_mask #(.NUM_MASKED(NUM_MASKED)) i_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (cmd.init),
        .load  (cmd.load_cw),
        .wdata (cw_wdata),
        .mask  (ctrl_mask)
    );

    fpx_summary #(.NUM_MASKED(NUM_MASKED)) i_summary (
        .flags   (flags[NUM_MASKED-1:0]),
        .mask    (ctrl_mask),
        .summary (summary)
    );

    // Drive the outward status and handshake signals.
    always_comb begin
        status_word = {summary, flags};
        trap_req    = cmd.trap;
        stall       = summary;
    end
endmodule

// File: rtl/fpx_trap_unit_chk.sv
// Property checker for fpx_trap_unit, attached by bind.
// Assumes instr_class only takes the six defined codes.
module fpx_trap_unit_chk #(
    parameter int NUM_MASKED = 6,
    localparam int NF = NUM_MASKED + 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  instr_valid,
    input logic [2:0]            instr_class,
    input logic [NF:0]           status_word,
    input logic [NUM_MASKED-1:0] ctrl_mask,
    input logic                  trap_req,
    input logic                  stall
);
    logic clr_cls, nowait_cls;
    // Classify the presented instruction for the properties below.
    always_comb begin
        clr_cls    = instr_valid && (instr_class == 3'd3 || instr_class == 3'd4 ||
                                     (instr_class == 3'd2 && !trap_req));
        nowait_cls = instr_valid && (instr_class == 3'd3 || instr_class == 3'd4 ||
                                     instr_class == 3'd5);
    end

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_cls |=> ((status_word[NF-1:0] & $past(status_word[NF-1:0])) == $past(status_word[NF-1:0]))); // R2
    AST_STACK_WITH_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[NF-1] |-> status_word[0]); // R3
    AST_TRAP_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> stall); // R6
    AST_TRAP_FREEZES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> $stable(status_word)); // R6
    AST_NOWAIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_class == 3'd3) |=> (status_word == '0)); // R8
    AST_INIT_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_class == 3'd4) |=> (&ctrl_mask && status_word == '0)); // R10
    AST_NOWAIT_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        nowait_cls |-> !trap_req); // R11
endmodule

bind fpx_trap_unit fpx_trap_unit_chk #(.NUM_MASKED(NUM_MASKED)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_class (instr_class),
    .status_word (status_word),
    .ctrl_mask   (ctrl_mask),
    .trap_req    (trap_req),
    .stall       (stall)
);

// File: tb/test_fpx_trap_unit.sv
// Directed bench for fpx_trap_unit: one task per scenario.
module test_fpx_trap_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0;
    logic [2:0] instr_class = 3'd0;
    logic [6:0] exc_in = 7'd0;
    logic [5:0] cw_wdata = 6'd0;
    logic [7:0] status_word;
    logic [5:0] ctrl_mask;
    logic       trap_req;
    logic       stall;
    int         checks = 0;
    int         errors = 0;
    logic       done = 1'b0;

    always #5 clk = ~clk;

    fpx_trap_unit i_fpx_trap_unit (
        .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid),
        .instr_class (instr_class), .exc_in (exc_in), .cw_wdata (cw_wdata),
        .status_word (status_word), .ctrl_mask (ctrl_mask),
        .trap_req (trap_req), .stall (stall)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Present one instruction at a negedge; return trap_req seen during it.
    task automatic issue(input logic [2:0] cls, input logic [6:0] exc, input logic [5:0] cw, output logic trap);
        instr_valid = 1'b1; instr_class = cls; exc_in = exc; cw_wdata = cw;
        #1 trap = trap_req;
        @(posedge clk); @(negedge clk);
        instr_valid = 1'b0; exc_in = 7'd0;
    endtask

    task automatic t_reset;
        chk("R1", "status in reset", status_word, 8'h00);
        chk("R1", "mask in reset", ctrl_mask, 6'h3F);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "status after reset", status_word, 8'h00);
        chk("R1", "trap after reset", trap_req, 1'b0);
        chk("R1", "mask after reset", ctrl_mask, 6'h3F);
    endtask

    task automatic t_masked_sticky;
        logic t;
        issue(3'd0, 7'h04, 6'h0, t);
        chk("R4", "zero-divide masked trap", t, 1'b0);
        chk("R4", "masked flag only", status_word, 8'h04);
        issue(3'd0, 7'h20, 6'h0, t);
        chk("R2", "flags accumulate", status_word, 8'h24);
        issue(3'd0, 7'h00, 6'h0, t);
        chk("R2", "flags sticky on clean op", status_word, 8'h24);
        chk("R7", "no trap without pending", t, 1'b0);
    endtask

    task automatic t_stack_fault;
        logic t;
        issue(3'd3, 7'h00, 6'h0, t);
        chk("R8", "nowait clear", status_word, 8'h00);
        issue(3'd0, 7'h40, 6'h0, t);
        chk("R3", "stack fault sets invalid", status_word, 8'h41);
    endtask

    task automatic t_unmask_pending;
        logic t;
        issue(3'd5, 7'h00, 6'h3E, t);
        chk("R11", "load no trap", t, 1'b0);
        chk("R11", "mask loaded", ctrl_mask, 6'h3E);
        chk("R5", "unmask exposes flag", status_word, 8'hC1);
        chk("R12", "stall follows summary", stall, 1'b1);
    endtask

    task automatic t_trap_refuse;
        logic t;
        issue(3'd0, 7'h04, 6'h0, t);
        chk("R6", "op traps", t, 1'b1);
        chk("R6", "trapped op ignored", status_word, 8'hC1);
        issue(3'd1, 7'h00, 6'h0, t);
        chk("R6", "wait traps", t, 1'b1);
        issue(3'd2, 7'h00, 6'h0, t);
        chk("R6", "waiting clear traps", t, 1'b1);
        chk("R6", "waiting clear refused", status_word, 8'hC1);
        issue(3'd3, 7'h00, 6'h0, t);
        chk("R8", "nowait clear no trap", t, 1'b0);
        chk("R8", "nowait clear while pending", status_word, 8'h00);
        chk("R12", "stall released", stall, 1'b0);
    endtask

    task automatic t_unmasked_flow;
        logic t;
        issue(3'd0, 7'h01, 6'h0, t);
        chk("R5", "unmasked invalid raises summary", status_word, 8'h81);
        issue(3'd0, 7'h02, 6'h0, t);
        chk("R6", "next op traps", t, 1'b1);
        chk("R6", "denormal ignored", status_word, 8'h81);
        issue(3'd3, 7'h00, 6'h0, t);
        issue(3'd0, 7'h20, 6'h0, t);
        chk("R4", "precision masked", status_word, 8'h20);
        issue(3'd1, 7'h00, 6'h0, t);
        chk("R7", "wait no trap", t, 1'b0);
        issue(3'd2, 7'h00, 6'h0, t);
        chk("R9", "waiting clear no trap", t, 1'b0);
        chk("R9", "waiting clear clears", status_word, 8'h00);
    endtask

    task automatic t_init;
        logic t;
        issue(3'd5, 7'h00, 6'h20, t);
        issue(3'd0, 7'h04, 6'h0, t);
        chk("R5", "zero-divide unmasked", status_word, 8'h84);
        issue(3'd4, 7'h00, 6'h0, t);
        chk("R10", "init no trap", t, 1'b0);
        chk("R10", "init clears flags", status_word, 8'h00);
        chk("R10", "init presets masks", ctrl_mask, 6'h3F);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_masked_sticky();
        t_stack_fault();
        t_unmask_pending();
        t_trap_refuse();
        t_unmasked_flow();
        t_init();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule